// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares a reference clock against the divided feedback clock of a synthesizer loop and drives two pump-control outputs: `up_o` asks the oscillator to speed up, `dn_o` asks it to slow down. Both inputs are treated as slow signals. They are brought into a fast sampling clock domain, and only their rising edges matter. Each side owns a sticky flag that a rising edge on that side sets. Once both flags are set, a programmable hold timer lets the two outputs overlap for a fixed number of sampling cycles and then clears both flags together. Because of this overlap, every comparison produces a pulse on both outputs, even when the phase error is zero. The effect of the analog dead zone is therefore removed.

The width difference between the two pulses equals the phase error in sampling cycles, and its sign gives the direction of the error. When the two inputs run at different frequencies, one output stays high for most of the time while the other only emits short hold-length pulses. This drives the loop steadily towards lock, with a capture range of a full cycle in either direction.

Top module: `phase_freq_detector`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `up_o` and `dn_o` are both 0. The reset is asynchronous and active low.
- R2: If the reference rises d sampling cycles before the feedback, `up_o` forms one pulse of d+H cycles and `dn_o` one pulse of H cycles. H is the effective hold count.
- R3: If the feedback rises d cycles before the reference, `dn_o` forms one pulse of d+H cycles and `up_o` one pulse of H cycles.
- R4: With zero offset, both outputs rise and fall in the same cycles and each is H cycles wide. The two outputs always fall in the same cycle.
- R5: H equals `hold_cycles_i` for values 1 to 15, and a value of 0 acts as 1. The cycle after the internal clear, both outputs are 0.
- R6: A rising input that is driven just before clock edge k makes its output high after edge k+2. This is the third edge, with two synchronizer stages.
- R7: A rising edge whose detection falls in the clear cycle is not lost. Its output is 0 for that one cycle and 1 on the next.
- R8: If the reference runs faster than the feedback, `up_o` is high for more than twice as many cycles as `dn_o`. If the feedback runs faster, the roles swap.
- R9: A second rising edge on a side whose flag is already set, and not being cleared, has no effect. The pulse widths stay as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous |
| fb_clk_i | input | 1 | Divided feedback clock, asynchronous |
| hold_cycles_i | input | DLY_W | Overlap hold count H (0 acts as 1) |
| up_o | output | 1 | Speed-up request |
| dn_o | output | 1 | Slow-down request |

## Verification
Single comparisons with random hold counts and random offsets are applied with the reference leading, the feedback leading, and zero offset. Comparing the two widths shows whether the sign and size of the offset are mapped to the correct output, and whether the overlap equals H. Directed cases cover a hold of 0, a repeated reference edge, the output latency, and an edge that lands exactly in the clear cycle; these tell clamping, edge ignoring and pending capture apart. Two runs with mismatched input frequencies, one in each direction, show that the detector produces a one-sided pulse train rather than a symmetric one.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    localparam int SIDE_REF = 0;
    localparam int SIDE_FB  = 1;
    localparam int N_SIDES  = 2;

    typedef struct packed {
        logic [N_SIDES-1:0] flag;
        logic [N_SIDES-1:0] pend;
    } pfd_state_t;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic rise_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], din_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // synchronized level high now, low one cycle earlier
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pfd_hold_timer.sv
module pfd_hold_timer #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             both_i,
    input  logic [DLY_W-1:0] hold_i,
    output logic             clr_o
);
    logic [DLY_W-1:0] cnt_d, cnt_q;
    logic [DLY_W-1:0] eff;

    always_comb begin
        eff   = (hold_i == '0) ? DLY_W'(1) : hold_i;
        clr_o = both_i && (cnt_q == eff - DLY_W'(1));
        if (!both_i || clr_o) cnt_d = '0;
        else                  cnt_d = cnt_q + DLY_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/phase_freq_detector.sv
module phase_freq_detector
    import pfd_pkg::*;
#(
    parameter int DLY_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_smp,
    input  logic             rst_n,
    input  logic             ref_clk_i,
    input  logic             fb_clk_i,
    input  logic [DLY_W-1:0] hold_cycles_i,
    output logic             up_o,
    output logic             dn_o
);
    logic [N_SIDES-1:0] raw_in;
    logic [N_SIDES-1:0] rise_w;
    logic               clr_w;
    pfd_state_t         st_d, st_q;

    assign raw_in[SIDE_REF] = ref_clk_i;
    assign raw_in[SIDE_FB]  = fb_clk_i;

    generate
        for (genvar g = 0; g < N_SIDES; g++) begin : g_side
            pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk    (clk_smp),
                .rst_n  (rst_n),
                .din_i  (raw_in[g]),
                .rise_o (rise_w[g])
            );
        end
    endgenerate

    pfd_hold_timer #(.DLY_W(DLY_W)) u_timer (
        .clk    (clk_smp),
        .rst_n  (rst_n),
        .both_i (&st_q.flag),
        .hold_i (hold_cycles_i),
        .clr_o  (clr_w)
    );

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < N_SIDES; s++) begin
            if (clr_w) begin
                st_d.flag[s] = 1'b0;
                st_d.pend[s] = rise_w[s];   // keep edge seen during clear
            end else begin
                st_d.flag[s] = st_q.flag[s] | rise_w[s] | st_q.pend[s];
                st_d.pend[s] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_smp or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_o = st_q.flag[SIDE_REF];
    assign dn_o = st_q.flag[SIDE_FB];
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
    parameter int DLY_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up,
    input logic             dn,
    input logic [DLY_W-1:0] hold,
    input logic             clr,
    input logic [1:0]       rise
);
    localparam int CW = DLY_W + 1;

    logic [CW-1:0] ovl_q;
    logic [CW-1:0] eff;

    assign eff = (hold == '0) ? CW'(1) : CW'(hold);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovl_q <= '0;
        else if (up && dn) ovl_q <= ovl_q + CW'(1);
        else               ovl_q <= '0;
    end

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!up && !dn));

    p_joint_fall_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up) |-> $fell(dn));

    p_joint_fall_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dn) |-> $fell(up));

    p_overlap_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up) |-> (ovl_q == eff));

    p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!up && !dn));

    p_pending_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rise[0]) |=> !up ##1 up);

    p_pending_fb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rise[1]) |=> !dn ##1 dn);
endmodule

bind phase_freq_detector pfd_checker #(.DLY_W(DLY_W)) u_chk (
    .clk   (clk_smp),
    .rst_n (rst_n),
    .up    (up_o),
    .dn    (dn_o),
    .hold  (hold_cycles_i),
    .clr   (clr_w),
    .rise  (rise_w)
);

// File: tb/phase_freq_detector_bench.sv
module phase_freq_detector_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [3:0] hold = 4'd1;
    logic       up, dn;

    int total = 0;
    int bad = 0;
    int up_run = 0, dn_run = 0, up_w = 0, dn_w = 0, up_n = 0, dn_n = 0;

    always #4 clk = ~clk;

    phase_freq_detector u_phase_freq_detector (
        .clk_smp       (clk),
        .rst_n         (rst_n),
        .ref_clk_i     (ref_in),
        .fb_clk_i      (fb_in),
        .hold_cycles_i (hold),
        .up_o          (up),
        .dn_o          (dn)
    );

    always @(negedge clk) begin
        if (up) up_run++;
        else if (up_run != 0) begin up_w = up_run; up_n++; up_run = 0; end
        if (dn) dn_run++;
        else if (dn_run != 0) begin dn_w = dn_run; dn_n++; dn_run = 0; end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_up_w(int d, int h, bit ref_first);
        return ref_first ? d + h : h;
    endfunction

    function automatic int exp_dn_w(int d, int h, bit ref_first);
        return ref_first ? h : d + h;
    endfunction

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic trial(input int dly, input int d, input bit ref_first, input string tag);
        int h, n0u, n0d, eu, ed;
        h = (dly == 0) ? 1 : dly;
        @(negedge clk); hold = 4'(dly);
        repeat (3) @(negedge clk);
        n0u = up_n; n0d = dn_n;
        if (d == 0) begin
            ref_in = 1'b1; fb_in = 1'b1;
        end else begin
            if (ref_first) ref_in = 1'b1; else fb_in = 1'b1;
            repeat (d) @(negedge clk);
            ref_in = 1'b1; fb_in = 1'b1;
        end
        repeat (d + h + 8) @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (5) @(negedge clk);
        eu = (d == 0) ? h : exp_up_w(d, h, ref_first);
        ed = (d == 0) ? h : exp_dn_w(d, h, ref_first);
        check(up_n == n0u + 1, {tag, " up pulse count"}, up_n - n0u, 1);
        check(dn_n == n0d + 1, {tag, " dn pulse count"}, dn_n - n0d, 1);
        check(up_w == eu, {tag, " up width"}, up_w, eu);
        check(dn_w == ed, {tag, " dn width"}, dn_w, ed);
    endtask

    task automatic freq_run(input int rp, input int fp, input bit up_side, input string tag);
        int cu, cd;
        cu = 0; cd = 0;
        pulse_reset();
        hold = 4'd2;
        for (int i = 0; i < 280; i++) begin
            @(negedge clk);
            if (up) cu++;
            if (dn) cd++;
            ref_in = (i % rp) < (rp / 2);
            fb_in  = (i % fp) < (fp / 2);
        end
        if (up_side) begin
            check(cu > 2 * cd, {tag, " up dominates"}, cu, 2 * cd);
            check(cd > 0, {tag, " dn spikes present"}, cd, 1);
        end else begin
            check(cd > 2 * cu, {tag, " dn dominates"}, cd, 2 * cu);
            check(cu > 0, {tag, " up spikes present"}, cu, 1);
        end
        pulse_reset();
    endtask

    initial begin
        int dly, d;
        bit rf;
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!up && !dn, "R1 during reset", {up, dn}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!up && !dn, "R1 after release", {up, dn}, 0);
        repeat (3) @(negedge clk);

        // R6: latency
        hold = 4'd3;
        @(negedge clk); ref_in = 1'b1;
        repeat (2) @(negedge clk);
        check(!up, "R6 up still low after two edges", up, 0);
        @(negedge clk);
        check(up, "R6 up high after third edge", up, 1);
        fb_in = 1'b1;
        repeat (12) @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (5) @(negedge clk);

        // R4 and R5: zero offset and clamped hold
        trial(5, 0, 1'b1, "R4 zero offset h5");
        trial(0, 4, 1'b1, "R5 hold zero acts as one");
        trial(15, 3, 1'b0, "R5 max hold lag");

        // R2 and R3: random leads and lags
        for (int t = 0; t < 16; t++) begin
            dly = $urandom_range(15, 1);
            d   = $urandom_range(12, 1);
            rf  = 1'($urandom_range(1, 0));
            trial(dly, d, rf, rf ? "R2 ref leads" : "R3 fb leads");
        end

        // R9: second reference edge while flag set
        @(negedge clk); hold = 4'd3;
        repeat (3) @(negedge clk);
        begin
            int n0u, n0d;
            n0u = up_n; n0d = dn_n;
            ref_in = 1'b1;
            repeat (3) @(negedge clk); ref_in = 1'b0;
            repeat (4) @(negedge clk); ref_in = 1'b1;
            repeat (9) @(negedge clk); fb_in = 1'b1;
            repeat (12) @(negedge clk);
            ref_in = 1'b0; fb_in = 1'b0;
            repeat (5) @(negedge clk);
            check(up_n == n0u + 1, "R9 single up pulse", up_n - n0u, 1);
            check(up_w == 19, "R9 up width", up_w, 19);
            check(dn_w == 3, "R9 dn width", dn_w, 3);
        end

        // R7: reference edge detected in the clear cycle (H=4)
        pulse_reset();
        hold = 4'd4;
        @(negedge clk);
        ref_in = 1'b1; fb_in = 1'b1;
        repeat (3) @(negedge clk); ref_in = 1'b0;
        @(negedge clk); ref_in = 1'b1;
        repeat (3) @(negedge clk);
        check(!up && !dn, "R7 low in clear cycle", {up, dn}, 0);
        @(negedge clk);
        check(up && !dn, "R7 pending edge captured", {up, dn}, 2);
        fb_in = 1'b0;
        repeat (2) @(negedge clk); fb_in = 1'b1;
        repeat (12) @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (5) @(negedge clk);

        // R8: frequency steps
        freq_run(6, 14, 1'b1, "R8 ref faster");
        freq_run(14, 6, 1'b0, "R8 fb faster");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule